// File: doc/BRIEF.md
# Serial Flash Read Command Front-End

This block is the slave-side serial interface of a NOR flash, limited to the commands that return data. It watches the chip-enable, serial clock and serial input pins, decodes an 8-bit opcode, and gathers a 24-bit address and an optional dummy byte. It then streams bytes back on the serial output pin, or on both data pins in dual-output mode. Array bytes come from a synchronous byte-read port that answers one system clock after a request. Identification bytes come from constants held in the block.

The pins are oversampled by a system clock `clk`. SCK edges are found by comparing SCK with its value one `clk` earlier. Each SCK half-period must last at least four `clk` cycles. The output drivers are modelled as a value and an enable per pin, so the pad ring builds the high-impedance state.

Top module: `spi_read_frontend`

## Requirements
- R1: The opcode, address and data bits are transferred MSB first. Input bits are taken on a rising SCK edge. Output bits change only after a falling SCK edge. The SCK level while CE_n is high may be low (mode 0) or high (mode 3).
- R2: Opcode 0x03, followed by a 24-bit address, returns array data starting at that address. The first data bit follows the falling SCK edge after the last address bit.
- R3: Opcodes 0x0B and 0x3B take eight dummy clocks after the address, before any data is returned.
- R4: For opcode 0x3B, each byte takes four clocks. On each clock, `so_o` carries the odd bit and `io0_o` carries the even bit below it: first bits 7/6, then 5/4, then 3/2, then 1/0. `io0_oe` is high only in this mode.
- R5: While CE_n stays low, read data continues from consecutive addresses. After address 0x7FFFF the stream continues at 0x00000.
- R6: Only address bits [18:0] choose the array byte. Bits [23:19] have no effect on the data returned.
- R7: Opcode 0x9F returns the bytes 0x8C, 0x20 and 0x13 in that order. The three-byte sequence then repeats.
- R8: Opcode 0x90, followed by a 24-bit address, returns bytes that alternate between 0x8C and 0x12. The stream starts with 0x8C when address bit 0 is 0, and with 0x12 when it is 1.
- R9: `so_oe` is low at reset, while CE_n is high, and before the first data falling edge of a command. Once raised within a command, it stays high until CE_n rises.
- R10: A rise of CE_n at any point aborts the command. The next command is decoded from its first bit. An opcode the block does not serve leaves both output enables low.
- R11: A memory read of N bytes raises `mem_re` exactly N+1 times. This is one prefetch at the end of the address, plus one prefetch per byte started. `mem_re` is raised only while CE_n was low in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in (IO0 in input phases) |
| so_o | output | 1 | Serial data out / IO1 value |
| so_oe | output | 1 | Output enable for so_o |
| io0_o | output | 1 | IO0 value in dual-output mode |
| io0_oe | output | 1 | Output enable for IO0 |
| mem_re | output | 1 | Byte read strobe to the array |
| mem_addr | output | AW | Array byte address |
| mem_rdata | input | 8 | Array byte, valid one clock after mem_re |

## Verification
The bench reads across the top of the array. A pointer that failed to wrap would return bytes from a nonexistent address, which the bench would see as mismatches. It sets the upper address bits on purpose, so a decoder that used them would fetch the wrong location. It aborts commands both mid-opcode and mid-data, then checks that a new command decodes cleanly. It runs a mode 3 transfer, where the first SCK edge is falling, and a dual read, where a swapped bit pairing shows up as corrupted bytes. It also counts memory strobes to catch a prefetch that is missing or issued twice.

// File: rtl/spi_read_frontend.sv
module spi_read_frontend #(
  parameter int AW = 19,
  parameter logic [7:0] MFR_ID  = 8'h8C,
  parameter logic [7:0] TYPE_ID = 8'h20,
  parameter logic [7:0] CAP_ID  = 8'h13,
  parameter logic [7:0] DEV_ID  = 8'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          sck,
  input  logic          si,
  output logic          so_o,
  output logic          so_oe,
  output logic          io0_o,
  output logic          io0_oe,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_DUAL = 8'h3B;
  localparam logic [7:0] OP_JID  = 8'h9F;
  localparam logic [7:0] OP_RID  = 8'h90;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_DUMMY, S_DATA, S_SKIP} st_t;
  typedef enum logic [1:0] {K_MEM, K_JID, K_RID} kind_t;

  st_t          st;
  kind_t        kind;
  logic         sck_q, fast, dual, fetch, re_q;
  logic [4:0]   cnt;
  logic [23:0]  shin;
  logic [AW-1:0] ptr;
  logic [7:0]   fetched, sh, src;
  logic [1:0]   idx;
  logic [2:0]   bpos;
  logic [7:0]   opc;

  wire rise = sck & ~sck_q;
  wire fall = ~sck & sck_q;
  wire [2:0] last = dual ? 3'd3 : 3'd7;

  assign mem_re   = fetch;
  assign mem_addr = ptr;
  assign opc      = {shin[6:0], si};

  always_comb begin
    case (kind)
      K_JID:   src = (idx == 2'd0) ? MFR_ID : (idx == 2'd1) ? TYPE_ID : CAP_ID;
      K_RID:   src = idx[0] ? DEV_ID : MFR_ID;
      default: src = fetched;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OP; kind <= K_MEM; sck_q <= 1'b0; fast <= 1'b0; dual <= 1'b0;
      fetch <= 1'b0; re_q <= 1'b0; cnt <= '0; shin <= '0; ptr <= '0;
      fetched <= '0; sh <= '0; idx <= '0; bpos <= '0;
      so_o <= 1'b0; so_oe <= 1'b0; io0_o <= 1'b0; io0_oe <= 1'b0;
    end else begin
      sck_q <= sck;
      re_q  <= fetch;
      fetch <= 1'b0;
      if (re_q) fetched <= mem_rdata;
      if (ce_n) begin
        st <= S_OP; cnt <= '0; bpos <= '0;
        so_oe <= 1'b0; io0_oe <= 1'b0;
      end else begin
        case (st)
          S_OP: if (rise) begin
            shin <= {shin[22:0], si};
            cnt  <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0; fast <= 1'b0; dual <= 1'b0; kind <= K_MEM;
              case (opc)
                OP_READ: st <= S_ADDR;
                OP_FAST: begin st <= S_ADDR; fast <= 1'b1; end
                OP_DUAL: begin st <= S_ADDR; fast <= 1'b1; dual <= 1'b1; end
                OP_JID:  begin st <= S_DATA; kind <= K_JID; idx <= 2'd0; end
                OP_RID:  begin st <= S_ADDR; kind <= K_RID; end
                default: st <= S_SKIP;
              endcase
            end
          end
          S_ADDR: if (rise) begin
            shin <= {shin[22:0], si};
            cnt  <= cnt + 5'd1;
            if (cnt == 5'd23) begin
              cnt   <= '0;
              ptr   <= {shin[AW-2:0], si};
              idx   <= {1'b0, si};
              fetch <= (kind == K_MEM);
              st    <= fast ? S_DUMMY : S_DATA;
            end
          end
          S_DUMMY: if (rise) begin
            cnt <= cnt + 5'd1;
            if (cnt == 5'd7) begin
              cnt <= '0;
              st  <= S_DATA;
            end
          end
          S_DATA: if (fall) begin
            so_oe  <= 1'b1;
            io0_oe <= dual;
            if (bpos == 3'd0) begin
              so_o  <= src[7];
              io0_o <= dual ? src[6] : io0_o;
              sh    <= dual ? {src[5:0], 2'b00} : {src[6:0], 1'b0};
              bpos  <= 3'd1;
              case (kind)
                K_MEM: begin ptr <= ptr + 1'b1; fetch <= 1'b1; end
                K_JID: idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
                default: idx[0] <= ~idx[0];
              endcase
            end else begin
              so_o  <= sh[7];
              io0_o <= dual ? sh[6] : io0_o;
              sh    <= dual ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
              bpos  <= (bpos == last) ? 3'd0 : bpos + 3'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module spi_read_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic sck,
  input logic so_o,
  input logic so_oe,
  input logic io0_o,
  input logic io0_oe,
  input logic mem_re
);
  p_oe_off_after_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!so_oe && !io0_oe));
  p_oe_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n) && $past(so_oe)) |-> so_oe);
  p_dual_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> so_oe);
  p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && $past(!ce_n) && so_o != $past(so_o)) |->
    ($past(!sck) && $past(sck, 2)));
  p_io0_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io0_oe && $past(io0_oe) && $past(!ce_n) && io0_o != $past(io0_o)) |->
    ($past(!sck) && $past(sck, 2)));
  p_re_in_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> $past(!ce_n));
endmodule

bind spi_read_frontend spi_read_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sck(sck), .so_o(so_o),
  .so_oe(so_oe), .io0_o(io0_o), .io0_oe(io0_oe), .mem_re(mem_re)
);

// File: tb/sim_spi_read_frontend.sv
module sim_spi_read_frontend;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so_o, so_oe, io0_o, io0_oe, mem_re;
  logic [18:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  int n_chk = 0, n_bad = 0, re_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_read_frontend u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sck(sck), .si(si),
    .so_o(so_o), .so_oe(so_oe), .io0_o(io0_o), .io0_oe(io0_oe),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [18:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ {5'd0, a[18:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= memf(mem_addr);
    if (rst_n && mem_re) re_cnt <= re_cnt + 1;
  end

  function automatic logic [7:0] expf(input logic [7:0] op, input logic [23:0] a, input int i);
    logic [18:0] p;
    p = a[18:0] + 19'(i);
    case (op)
      8'h9F:   return (i % 3 == 0) ? 8'h8C : (i % 3 == 1) ? 8'h20 : 8'h13;
      8'h90:   return (((int'(a[0]) + i) % 2) == 1) ? 8'h12 : 8'h8C;
      default: return memf(p);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input bit m3);
    sck = m3; wait_n(2); ce_n = 1'b0; wait_n(3);
  endtask

  task automatic stop();
    wait_n(2); ce_n = 1'b1; wait_n(2); sck = 1'b0; wait_n(4);
  endtask

  task automatic bit_in(input logic b);
    sck = 1'b0; si = b; wait_n(5); sck = 1'b1; wait_n(5);
  endtask

  task automatic byte_in(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
  endtask

  task automatic byte_out(input bit dl, output logic [7:0] v, output bit oe_ok);
    oe_ok = 1;
    if (dl) begin
      for (int k = 3; k >= 0; k--) begin
        sck = 1'b0; wait_n(5);
        v[2*k+1] = so_o; v[2*k] = io0_o;
        if (!so_oe || !io0_oe) oe_ok = 0;
        sck = 1'b1; wait_n(5);
      end
    end else begin
      for (int k = 7; k >= 0; k--) begin
        sck = 1'b0; wait_n(5);
        v[k] = so_o;
        if (!so_oe || io0_oe) oe_ok = 0;
        sck = 1'b1; wait_n(5);
      end
    end
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input int n,
                         input bit m3, input string req);
    logic [7:0] v;
    bit ok;
    bit dl;
    dl = (op == 8'h3B);
    start(m3);
    byte_in(op);
    if (op != 8'h9F) begin
      byte_in(a[23:16]); byte_in(a[15:8]); byte_in(a[7:0]);
    end
    if (op == 8'h0B || op == 8'h3B) begin
      byte_in(8'hA5);
      chk({req, " R3 oe off in dummy"}, {so_oe, io0_oe}, 2'b00);
    end
    for (int i = 0; i < n; i++) begin
      byte_out(dl, v, ok);
      chk(req, v, expf(op, a, i));
      chk({req, " R9 enables"}, ok, 1);
    end
    stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    int unsigned seed;
    seed = $urandom(32'd2024);
    wait_n(4); rst_n = 1'b1; wait_n(2);
    chk("R9 reset so_oe", so_oe, 0);
    chk("R9 reset io0_oe", io0_oe, 0);
    chk("R11 reset mem_re", mem_re, 0);

    base = re_cnt;
    run_cmd(8'h03, 24'h012345, 6, 0, "R2 R1 read mode0");
    chk("R11 strobe count", re_cnt - base, 7);
    run_cmd(8'h0B, 24'h000100, 4, 1, "R3 R1 fast read mode3");
    run_cmd(8'h3B, 24'h054321, 5, 0, "R4 dual read");
    run_cmd(8'h03, 24'h07FFFE, 4, 0, "R5 wrap");
    run_cmd(8'h0B, 24'hF80010, 3, 1, "R6 upper bits ignored");
    run_cmd(8'h9F, 24'h0, 6, 0, "R7 jedec id");
    run_cmd(8'h90, 24'h000000, 4, 0, "R8 id lsb0");
    run_cmd(8'h90, 24'h000001, 4, 1, "R8 id lsb1");

    start(0); bit_in(0); bit_in(0); bit_in(0); bit_in(0);
    ce_n = 1'b1; wait_n(3);
    chk("R10 abort mid-opcode oe", {so_oe, io0_oe}, 2'b00);
    stop();
    run_cmd(8'h9F, 24'h0, 1, 0, "R10 fresh decode after abort");

    start(0); byte_in(8'h03); byte_in(8'h00); byte_in(8'h10); byte_in(8'h00);
    sck = 1'b0; wait_n(5); sck = 1'b1; wait_n(5); sck = 1'b0; wait_n(5);
    ce_n = 1'b1; wait_n(3);
    chk("R10 R9 abort mid-data oe", {so_oe, io0_oe}, 2'b00);
    stop();
    run_cmd(8'h03, 24'h000200, 2, 0, "R10 read after data abort");

    start(0); byte_in(8'h05);
    begin
      bit bad_oe;
      bad_oe = 0;
      for (int i = 0; i < 16; i++) begin
        bit_in(1'b1);
        if (so_oe || io0_oe) bad_oe = 1;
      end
      chk("R10 unknown opcode outputs off", bad_oe, 0);
    end
    stop();

    for (int it = 0; it < 14; it++) begin
      logic [7:0] op;
      int sel;
      sel = $urandom_range(0, 4);
      op = (sel == 0) ? 8'h03 : (sel == 1) ? 8'h0B : (sel == 2) ? 8'h3B :
           (sel == 3) ? 8'h9F : 8'h90;
      run_cmd(op, 24'($urandom), $urandom_range(1, 5), 1'($urandom_range(0, 1)),
              "R2 R4 R5 R7 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule